// File: doc/BRIEF.md
# Chained-Descriptor Memory Card DMA Engine

This block moves data between system memory and the data FIFO of a memory-card host interface. It takes its work from linked descriptors held in memory. Software builds one or more four-word descriptors, marks them as handed to the engine, and pulses `start` with the address of the first descriptor and the direction. The engine reads each descriptor over a simple bus master port. If the descriptor still belongs to software, the engine parks in a suspend state. Otherwise it waits until the card interface reports that the command finished cleanly. It then moves words whenever the FIFO raises its watermark request.

Data moves in four-word bursts while at least sixteen bytes remain. Any shorter tail moves as single beats. When a buffer is drained, the engine writes word 0 back with the ownership flag cleared. It then either follows the next-descriptor pointer or, at the last descriptor, raises a completion status bit. A small register file holds the status bits (write-1-to-clear), the interrupt enables and a poll-demand register that wakes a suspended engine.

Top module: `card_desc_dma`

## Requirements
- R1: After reset the engine issues no bus request, `irq` is low, and the status (register address 0) and enable (register address 1) registers both read zero.
- R2: A descriptor is fetched as four single reads at ascending word addresses from the descriptor address. Word 0 bit 31 is the engine-owns flag and bit 30 marks the last descriptor. Word 1 holds the byte count, a multiple of 4. Word 2 holds the buffer address and word 3 holds the next-descriptor address.
- R3: If the fetched word 0 has bit 31 clear, the engine moves no data, stays suspended, and sets status bit 2 (descriptor unavailable) whatever the enables hold.
- R4: A write of any value to register address 2 makes a suspended engine fetch the same descriptor again. The same write has no effect while the engine is idle.
- R5: No data beat is issued until `cmd_done` is high and `cmd_err` is low together.
- R6: A data transfer (burst or single) begins only while `fifo_req` is high. Once a burst has begun it runs to its fourth beat.
- R7: While 16 or more bytes remain, data moves as 4-beat bursts with `bus_burst` high. A remainder below 16 bytes moves as single beats with `bus_burst` low. The remaining count drops by 4 for each accepted beat.
- R8: In transmit (`dir_rx` = 0), buffer words are read at ascending addresses and presented on `fifo_wdata` with `fifo_wr`, in order.
- R9: In receive (`dir_rx` = 1), words taken from the FIFO with `fifo_rd` are written to ascending buffer addresses, in order.
- R10: After the data of a descriptor without the last bit, the engine writes that descriptor back and then fetches the descriptor at its word-3 address.
- R11: After each descriptor's data, word 0 is written back to the descriptor address with bit 31 cleared and every other bit unchanged.
- R12: When the last descriptor has been written back, status bit 0 (transmit) or bit 1 (receive) is set, but only if the same bit of the enable register is set. Writing 1 to a status bit clears it.
- R13: `irq` is high exactly when some status bit and its enable bit are both set.
- R14: Once raised, `bus_req` holds with unchanged `bus_addr` and `bus_we` until a cycle with `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse in idle: begin a descriptor chain |
| dir_rx | input | 1 | Direction taken at start: 0 memory to FIFO, 1 FIFO to memory |
| desc_base | input | AW | Address of the first descriptor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 poll demand |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| cmd_done | input | 1 | Card interface: command finished |
| cmd_err | input | 1 | Card interface: any error flag |
| fifo_req | input | 1 | FIFO watermark request |
| fifo_wr | output | 1 | Transmit word pushed into the FIFO this cycle |
| fifo_wdata | output | 32 | Transmit word |
| fifo_rd | output | 1 | Receive word popped from the FIFO this cycle |
| fifo_rdata | input | 32 | Head word of the receive FIFO |
| bus_req | output | 1 | Bus master request, one beat per acknowledged cycle |
| bus_we | output | 1 | 1 write, 0 read |
| bus_burst | output | 1 | Beat belongs to a 4-beat burst |
| bus_addr | output | AW | Beat byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Beat accepted |

## Verification
The bench runs the engine under the following patterns:
- A 24-byte transmit with a stalling bus slave. This separates the burst part from the single-beat tail and shows that requests hold through stalls.
- A 16-byte transmit started with the command still open, then with an error flag raised, then with the FIFO request low. This tells the command gate apart from the watermark gate.
- A descriptor handed over unowned, then released with a poll write. This exercises suspend and resume.
- A two-descriptor chain whose counts give one burst followed by three singles. This shows the link walk and the write-back of both descriptors.
- A receive run, and a transmit run with its completion interrupt disabled. These show the mirror direction and the enable gating of the status bits.

// File: rtl/cdd_pkg.sv
package cdd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_SUSP, S_CMDW, S_XWAIT, S_DATA, S_WBACK
  } eng_st_e;

  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 30;

  localparam int NSTS   = 3;
  localparam int STS_TX = 0;
  localparam int STS_RX = 1;
  localparam int STS_DU = 2;

  localparam logic [1:0] RA_STS  = 2'd0;
  localparam logic [1:0] RA_EN   = 2'd1;
  localparam logic [1:0] RA_POLL = 2'd2;
endpackage

// File: rtl/cdd_rst_sync.sv
module cdd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/cdd_regs.sv
module cdd_regs
  import cdd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NSTS-1:0] reg_wdata,
  output logic [NSTS-1:0] reg_rdata,
  input  logic            set_tx,
  input  logic            set_rx,
  input  logic            set_du,
  output logic            poll,
  output logic            irq
);
  logic [NSTS-1:0] sts_q, sts_d, en_q, en_d, clr, hw_set;

  always_comb begin
    clr    = (reg_wr && reg_addr == RA_STS) ? reg_wdata : '0;
    hw_set = '0;
    hw_set[STS_TX] = set_tx & en_q[STS_TX];
    hw_set[STS_RX] = set_rx & en_q[STS_RX];
    hw_set[STS_DU] = set_du;
    sts_d  = (sts_q & ~clr) | hw_set;
    en_d   = (reg_wr && reg_addr == RA_EN) ? reg_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign poll      = reg_wr && (reg_addr == RA_POLL);
  assign irq       = |(sts_q & en_q);
  assign reg_rdata = (reg_addr == RA_STS) ? sts_q :
                     (reg_addr == RA_EN)  ? en_q  : '0;

  // R12
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_STS && reg_wdata[STS_TX] && !set_tx) |=> !sts_q[STS_TX]);

  // R3
  du_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_du |=> sts_q[STS_DU]);
endmodule

// File: rtl/cdd_engine.sv
module cdd_engine
  import cdd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_rx,
  input  logic [AW-1:0] desc_base,
  input  logic          poll,
  input  logic          cmd_done,
  input  logic          cmd_err,
  input  logic          fifo_req,
  output logic          fifo_wr,
  output logic [31:0]   fifo_wdata,
  output logic          fifo_rd,
  input  logic [31:0]   fifo_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_burst,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  output logic          set_tx,
  output logic          set_rx,
  output logic          set_du
);
  localparam int BB = BURST * 4;
  localparam int LW = $clog2(BURST + 1);

  eng_st_e       st_q, st_d;
  logic [1:0]    widx_q, widx_d;
  logic [31:0]   w0_q, w0_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] buf_q, buf_d, nxt_q, nxt_d, cur_q, cur_d;
  logic [LW-1:0] left_q, left_d;
  logic          brst_q, brst_d, rx_q, rx_d;

  always_comb begin
    st_d = st_q;   widx_d = widx_q; w0_d = w0_q;   cnt_d = cnt_q;
    buf_d = buf_q; nxt_d = nxt_q;   cur_d = cur_q; left_d = left_q;
    brst_d = brst_q; rx_d = rx_q;
    set_tx = 1'b0; set_rx = 1'b0; set_du = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        cur_d = desc_base; rx_d = dir_rx; widx_d = 2'd0; st_d = S_FETCH;
      end
      S_FETCH: if (bus_ack) begin
        case (widx_q)
          2'd0:    w0_d  = bus_rdata;
          2'd1:    cnt_d = bus_rdata[CW-1:0];
          2'd2:    buf_d = bus_rdata[AW-1:0];
          default: nxt_d = bus_rdata[AW-1:0];
        endcase
        widx_d = widx_q + 2'd1;
        if (widx_q == 2'd3) st_d = S_CHECK;
      end
      S_CHECK: if (w0_q[OWN_BIT]) st_d = S_CMDW;
               else begin set_du = 1'b1; st_d = S_SUSP; end
      S_SUSP: if (poll) begin widx_d = 2'd0; st_d = S_FETCH; end
      S_CMDW: if (cmd_done && !cmd_err) st_d = S_XWAIT;
      S_XWAIT: if (cnt_q == '0) st_d = S_WBACK;
               else if (fifo_req) begin
                 brst_d = (cnt_q >= CW'(BB));
                 left_d = (cnt_q >= CW'(BB)) ? LW'(BURST) : LW'(1);
                 st_d   = S_DATA;
               end
      S_DATA: if (bus_ack) begin
        buf_d  = buf_q + AW'(4);
        cnt_d  = cnt_q - CW'(4);
        left_d = left_q - LW'(1);
        if (left_q == LW'(1)) st_d = S_XWAIT;
      end
      S_WBACK: if (bus_ack) begin
        if (w0_q[LAST_BIT]) begin
          set_tx = !rx_q; set_rx = rx_q; st_d = S_IDLE;
        end else begin
          cur_d = nxt_q; widx_d = 2'd0; st_d = S_FETCH;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; widx_q <= '0; w0_q <= '0; cnt_q <= '0;
      buf_q <= '0; nxt_q <= '0; cur_q <= '0; left_q <= '0;
      brst_q <= 1'b0; rx_q <= 1'b0;
    end else begin
      st_q <= st_d; widx_q <= widx_d; w0_q <= w0_d; cnt_q <= cnt_d;
      buf_q <= buf_d; nxt_q <= nxt_d; cur_q <= cur_d; left_q <= left_d;
      brst_q <= brst_d; rx_q <= rx_d;
    end
  end

  always_comb begin
    bus_req   = (st_q == S_FETCH) || (st_q == S_DATA) || (st_q == S_WBACK);
    bus_we    = ((st_q == S_DATA) && rx_q) || (st_q == S_WBACK);
    bus_burst = (st_q == S_DATA) && brst_q;
    case (st_q)
      S_DATA:  bus_addr = buf_q;
      S_FETCH: bus_addr = cur_q + AW'({widx_q, 2'b00});
      default: bus_addr = cur_q;
    endcase
    bus_wdata = (st_q == S_WBACK) ? (w0_q & ~(32'd1 << OWN_BIT)) : fifo_rdata;
  end

  assign fifo_wr    = (st_q == S_DATA) && !rx_q && bus_ack;
  assign fifo_rd    = (st_q == S_DATA) &&  rx_q && bus_ack;
  assign fifo_wdata = bus_rdata;

  // R14
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R7
  burst_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst |-> (cnt_q >= CW'(left_q) * CW'(4)));

  // R7
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DATA && bus_ack) |=> (cnt_q == $past(cnt_q) - CW'(4)));

  // R4
  poll_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SUSP && poll) |=> (bus_req && !bus_we && bus_addr == $past(cur_q)));
endmodule

// File: rtl/card_desc_dma.sv
module card_desc_dma
  import cdd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int BURST = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dir_rx,
  input  logic [AW-1:0]   desc_base,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NSTS-1:0] reg_wdata,
  output logic [NSTS-1:0] reg_rdata,
  output logic            irq,
  input  logic            cmd_done,
  input  logic            cmd_err,
  input  logic            fifo_req,
  output logic            fifo_wr,
  output logic [31:0]     fifo_wdata,
  output logic            fifo_rd,
  input  logic [31:0]     fifo_rdata,
  output logic            bus_req,
  output logic            bus_we,
  output logic            bus_burst,
  output logic [AW-1:0]   bus_addr,
  output logic [31:0]     bus_wdata,
  input  logic [31:0]     bus_rdata,
  input  logic            bus_ack
);
  logic rst_core_n, poll, set_tx, set_rx, set_du;

  cdd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n));

  cdd_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_tx(set_tx),
    .set_rx(set_rx), .set_du(set_du), .poll(poll), .irq(irq)
  );

  cdd_engine #(.AW(AW), .CW(CW), .BURST(BURST)) u_eng (
    .clk(clk), .rst_n(rst_core_n), .start(start), .dir_rx(dir_rx),
    .desc_base(desc_base), .poll(poll), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .fifo_req(fifo_req), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_burst(bus_burst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .set_tx(set_tx), .set_rx(set_rx), .set_du(set_du)
  );
endmodule

// File: tb/sim_card_desc_dma.sv
module sim_card_desc_dma;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, dir_rx, reg_wr, cmd_done, cmd_err, fifo_req;
  logic [31:0] desc_base, fifo_rdata, bus_rdata;
  logic [1:0]  reg_addr;
  logic [2:0]  reg_wdata, reg_rdata;
  logic        irq, fifo_wr, fifo_rd, bus_req, bus_we, bus_burst, bus_ack;
  logic [31:0] fifo_wdata, bus_addr, bus_wdata;

  card_desc_dma #(.AW(32), .CW(16), .BURST(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx), .desc_base(desc_base),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .cmd_done(cmd_done), .cmd_err(cmd_err), .fifo_req(fifo_req),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_burst(bus_burst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  int n_tests = 0, n_fail = 0, nb = 0, ns = 0, stall = 0;
  bit done_flag = 0, pop_pend = 0, any_req = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rx_word;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus slave and FIFO source: drive just after the rising edge
  always begin
    @(posedge clk); #1;
    stall = (stall == 2) ? 0 : stall + 1;
    if (pop_pend) begin rx_word = rx_word + 1; pop_pend = 0; end
    fifo_rdata = rx_word;
    bus_ack    = bus_req && (stall != 2);
    bus_rdata  = mem[bus_addr[9:2]];
  end

  // monitor and scoreboard: sample at the falling edge
  always @(negedge clk) begin
    if (bus_req) any_req = 1;
    if (bus_req && bus_ack && bus_we) mem[bus_addr[9:2]] = bus_wdata;
    if (fifo_wr || fifo_rd) begin
      if (bus_burst) nb++; else ns++;
    end
    if (fifo_wr) begin
      if (txq.size() == 0) chk("R8", "unexpected transmit word", fifo_wdata, 32'hx);
      else chk("R8", "transmit word order", fifo_wdata, txq.pop_front());
    end
    if (fifo_rd) begin
      pop_pend = 1;
      if (rxq.size() == 0) chk("R9", "unexpected receive word", bus_wdata, 32'hx);
      else chk("R9", "receive word order", bus_wdata, rxq.pop_front());
    end
  end

  task automatic reg_write(logic [1:0] a, logic [2:0] d);
    @(posedge clk); #2; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2; reg_wr = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [2:0] v);
    @(posedge clk); #2; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic set_desc(int a, bit own, bit last, int cnt, int bufa, int nxt);
    mem[a>>2]     = {own, last, 30'h5A};
    mem[(a>>2)+1] = cnt;
    mem[(a>>2)+2] = bufa;
    mem[(a>>2)+3] = nxt;
  endtask

  task automatic load_tx(int bufa, int nbytes, logic [31:0] seed);
    for (int i = 0; i < nbytes / 4; i++) begin
      mem[(bufa>>2)+i] = seed + i;
      txq.push_back(seed + i);
    end
  endtask

  task automatic kick(int base, bit rx);
    nb = 0; ns = 0;
    @(posedge clk); #2; start = 1; dir_rx = rx; desc_base = base;
    @(posedge clk); #2; start = 0;
  endtask

  task automatic wait_own(int a, string req);
    int k = 0;
    while (mem[a>>2][31] && k < 3000) begin @(negedge clk); k++; end
    chk(req, "ownership flag returned", {31'd0, mem[a>>2][31]}, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] v;
    rst_n = 0; start = 0; dir_rx = 0; desc_base = 0; reg_wr = 0; reg_addr = 0;
    reg_wdata = 0; cmd_done = 0; cmd_err = 0; fifo_req = 0; fifo_rdata = 0;
    bus_rdata = 0; bus_ack = 0; rx_word = 32'hE000_0000;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(posedge clk); #2 rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "bus_req after reset", {31'd0, bus_req}, 0);
    chk("R1", "irq after reset", {31'd0, irq}, 0);
    reg_read(2'd0, v); chk("R1", "status after reset", {29'd0, v}, 0);
    reg_read(2'd1, v); chk("R1", "enable after reset", {29'd0, v}, 0);

    // R4 poll in idle is ignored
    any_req = 0;
    reg_write(2'd2, 3'd5);
    repeat (10) @(negedge clk);
    chk("R4", "poll while idle starts no bus access", {31'd0, any_req}, 0);

    // R2 R7 R8 R11 R12 R13 R14: 24-byte transmit, stalling slave
    reg_write(2'd1, 3'b111);
    cmd_done = 1; fifo_req = 1;
    set_desc(32'h00, 1, 1, 24, 32'h100, 0);
    load_tx(32'h100, 24, 32'hA000_0000);
    kick(32'h00, 0);
    wait_own(32'h00, "R2");
    chk("R8", "transmit queue drained", txq.size(), 0);
    chk("R7", "burst beats for 24 bytes", nb, 4);
    chk("R7", "single beats for 24 bytes", ns, 2);
    chk("R11", "written-back word 0", mem[0], 32'h4000_005A);
    reg_read(2'd0, v); chk("R12", "transmit status set", {29'd0, v}, 1);
    chk("R13", "irq with enabled status", {31'd0, irq}, 1);
    reg_write(2'd0, 3'b001);
    reg_read(2'd0, v); chk("R12", "write-1-to-clear", {29'd0, v}, 0);
    chk("R13", "irq after clear", {31'd0, irq}, 0);

    // R5 R6 gating on command status and watermark
    cmd_done = 0; fifo_req = 1;
    set_desc(32'h10, 1, 1, 16, 32'h140, 0);
    load_tx(32'h140, 16, 32'hB000_0000);
    kick(32'h10, 0);
    repeat (30) @(negedge clk);
    chk("R5", "no beats before command done", nb + ns, 0);
    cmd_err = 1; cmd_done = 1;
    repeat (20) @(negedge clk);
    chk("R5", "no beats with error flag", nb + ns, 0);
    fifo_req = 0; cmd_err = 0;
    repeat (20) @(negedge clk);
    chk("R6", "no beats without FIFO request", nb + ns, 0);
    fifo_req = 1;
    wait_own(32'h10, "R6");
    chk("R7", "one full burst for 16 bytes", nb, 4);
    chk("R7", "no singles for 16 bytes", ns, 0);
    chk("R8", "transmit queue drained", txq.size(), 0);
    reg_write(2'd0, 3'b111);

    // R3 R4 suspend and poll-demand resume
    set_desc(32'h20, 0, 1, 8, 32'h160, 0);
    load_tx(32'h160, 8, 32'hC100_0000);
    kick(32'h20, 0);
    repeat (30) @(negedge clk);
    reg_read(2'd0, v); chk("R3", "descriptor-unavailable status", {29'd0, v}, 4);
    chk("R3", "no beats while suspended", nb + ns, 0);
    chk("R13", "irq from unavailable status", {31'd0, irq}, 1);
    mem[32'h20>>2][31] = 1'b1;
    reg_write(2'd0, 3'b100);
    reg_write(2'd2, 3'd0);
    wait_own(32'h20, "R4");
    chk("R4", "data moved after poll", txq.size(), 0);
    reg_read(2'd0, v); chk("R4", "status after resumed run", {29'd0, v}, 1);
    reg_write(2'd0, 3'b111);

    // R10 R11 two-descriptor chain
    set_desc(32'h40, 1, 0, 20, 32'h180, 32'h60);
    set_desc(32'h60, 1, 1, 8, 32'h1C0, 0);
    load_tx(32'h180, 20, 32'hC000_0000);
    load_tx(32'h1C0, 8, 32'hD000_0000);
    kick(32'h40, 0);
    wait_own(32'h60, "R10");
    chk("R10", "chain data in order", txq.size(), 0);
    chk("R11", "first descriptor written back", mem[32'h40>>2], 32'h0000_005A);
    chk("R11", "last descriptor written back", mem[32'h60>>2], 32'h4000_005A);
    chk("R7", "chain burst beats", nb, 4);
    chk("R7", "chain single beats", ns, 3);
    reg_write(2'd0, 3'b111);

    // R9 R12 receive
    set_desc(32'h80, 1, 1, 20, 32'h200, 0);
    for (int i = 0; i < 5; i++) rxq.push_back(rx_word + i);
    kick(32'h80, 1);
    wait_own(32'h80, "R9");
    for (int i = 0; i < 5; i++)
      chk("R9", "receive buffer word", mem[(32'h200>>2)+i], 32'hE000_0000 + i);
    chk("R9", "receive queue drained", rxq.size(), 0);
    reg_read(2'd0, v); chk("R12", "receive status set", {29'd0, v}, 2);
    reg_write(2'd0, 3'b111);

    // R12 R13 completion with transmit interrupt disabled
    reg_write(2'd1, 3'b110);
    set_desc(32'hA0, 1, 1, 8, 32'h240, 0);
    load_tx(32'h240, 8, 32'hF000_0000);
    kick(32'hA0, 0);
    wait_own(32'hA0, "R12");
    reg_read(2'd0, v); chk("R12", "no status when disabled", {29'd0, v}, 0);
    chk("R13", "irq stays low when disabled", {31'd0, irq}, 0);

    done_flag = 1;
    summary();
    $finish;
  end
endmodule